// File: doc/BRIEF.md
# Exception Vector Remap Controller

This block sits between a 32-bit core and its on-chip memories and translates every fetch or read address into a physical target. The core always takes its exception vectors from the first eight words of the address space. A 2-bit remap control value picks which memory answers for that small window: the boot ROM, the user flash, or the on-chip SRAM. Every address outside the window keeps its natural location, so each memory stays reachable at its own address while it is also seen through the window. No data is copied; the window is a pure address alias.

Translation and region decode are combinational, so the physical address, the one-hot region selects and the decode-error flag are valid in the same cycle as the incoming address. The remap control value is held in a register on a small valid/write/address/data bus with a same-cycle ready. Reset selects boot mode, so the boot code runs first. Software later rewrites the field to hand the vectors to flash or to RAM.

Top module: `vec_remap_ctrl`

## Requirements
- R1: After reset the mode is boot (00): a read of the control register returns 0 and vector fetches go to the boot block. A later reset returns the block to this state.
- R2: In mode 00, a core address A in 0x00..0x1F maps to 0x7FFF_E000 + A, with sel_boot high.
- R3: In mode 10, a core address A in 0x00..0x1F maps to 0x4000_0000 + A, with sel_sram high.
- R4: In mode 01, a core address A in 0x00..0x1F passes through unchanged, with sel_flash high.
- R5: Mode 11 translates exactly like mode 01, and a read of the register returns 3.
- R6: Addresses of 0x20 and above pass through unchanged in every mode. Flash 0x0000_0000..0x0003_FFFF, SRAM 0x4000_0000..0x4000_3FFF and the boot block 0x7FFF_E000..0x7FFF_FFFF each assert their own select.
- R7: An address outside flash, SRAM, the boot block and the control register address (0xE01F_C040) raises decode_err with no select. The register address itself raises no select and no error.
- R8: A write with reg_valid=1, reg_write=1 and reg_addr=0xE01F_C040 stores reg_wdata[1:0] and ignores the upper bits. A read returns {30'b0, mode}. A write to any other address changes nothing. reg_rdata is 0 on any cycle that is not a read of the register address.
- R9: Accesses in the write cycle itself still use the old mode. The new mode applies from the following cycle.
- R10: reg_ready equals reg_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Core fetch or read address |
| phys_addr | output | 32 | Translated physical address |
| sel_flash | output | 1 | Target is user flash |
| sel_sram | output | 1 | Target is on-chip SRAM |
| sel_boot | output | 1 | Target is the boot block |
| decode_err | output | 1 | Address maps to no region |
| reg_valid | input | 1 | Register bus request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 32 | Register bus address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_ready | output | 1 | Request accepted this cycle |

## Verification
The mode register is the only state in the block. If it is corrupted, the error shows on the very next vector-window access: phys_addr points into the wrong region and the wrong select strobe fires. A read of the register shows the same fault in the cycle of the read. The reference model keeps its own copy of the mode and compares every output on every cycle. A bad update, an update one cycle early, or an update from upper data bits is therefore caught within one cycle of the write. The tests cover every mode, the window edges (0x1C, 0x1F, 0x20), the region bounds, and the unmapped gaps.

// File: rtl/remap_pkg.sv
// Package: shared types for the vector remap controller.
// Assumes a 2-bit mode field; encoding 11 is reserved and behaves as flash.
package remap_pkg;
    typedef enum logic [1:0] {
        MAP_BOOT  = 2'b00,
        MAP_FLASH = 2'b01,
        MAP_RAM   = 2'b10,
        MAP_RSVD  = 2'b11
    } map_mode_t;
endpackage

// File: rtl/remap_cfg_reg.sv
// Module: remap control register on a single-cycle valid/write bus.
// Holds the 2-bit mode; reset selects boot mode. Assumes a word-addressed
// register at CFG_ADDR; upper write-data bits are discarded.
module remap_cfg_reg
    import remap_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'hE01F_C040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_ready,
    output map_mode_t         mode
);
    logic hit;
    logic wr_en;
    wire  unused_wdata_hi = ^reg_wdata[DATA_W-1:2];

    // Address match and write qualifier.
    assign hit   = reg_valid && (reg_addr == CFG_ADDR);
    assign wr_en = hit && reg_write;

    // Mode storage: boot mode on reset, low two data bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MAP_BOOT;
        else if (wr_en)
            mode <= map_mode_t'(reg_wdata[1:0]);
    end

    // Read mux and same-cycle ready.
    always_comb begin
        reg_ready = reg_valid;
        reg_rdata = '0;
        if (hit && !reg_write)
            reg_rdata = {{(DATA_W-2){1'b0}}, mode};
    end

    assert_reset_boot_R1: assert property (@(posedge clk)
        !rst_n |=> mode == MAP_BOOT);

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mode == map_mode_t'($past(reg_wdata[1:0])));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode));
endmodule

// File: rtl/remap_vector_xlate.sv
// Module: vector window translation.
// Redirects the lowest VEC_WORDS words to the boot block or SRAM by mode;
// everything else passes through. Assumes VEC_WORDS is a power of two and
// both bases are aligned to the window size.
module remap_vector_xlate
    import remap_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                VEC_WORDS = 8,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 32'h7FFF_E000,
    parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h4000_0000
) (
    input  map_mode_t         mode,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int VEC_BYTES = VEC_WORDS * 4;
    localparam int VEC_BITS  = $clog2(VEC_BYTES);

    logic              in_window;
    logic [ADDR_W-1:0] offset;

    // Window hit and in-window byte offset.
    assign in_window = (cpu_addr[ADDR_W-1:VEC_BITS] == '0);
    assign offset    = {{(ADDR_W-VEC_BITS){1'b0}}, cpu_addr[VEC_BITS-1:0]};

    // Select the backing base for window accesses.
    always_comb begin
        phys_addr = cpu_addr;
        if (in_window) begin
            unique case (mode)
                MAP_BOOT:  phys_addr = BOOT_BASE | offset;
                MAP_RAM:   phys_addr = SRAM_BASE | offset;
                default:   phys_addr = offset;
            endcase
        end
    end

    always_comb begin
        assert_offset_kept_R2: assert (phys_addr[VEC_BITS-1:0] == cpu_addr[VEC_BITS-1:0]);
    end
endmodule

// File: rtl/remap_region_decode.sv
// Module: physical region decode.
// Raises one select for flash, SRAM or boot block, nothing for the control
// register address, and decode_err for anything else. Assumes the regions
// do not overlap.
module remap_region_decode #(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] FLASH_BYTES = 32'h0004_0000,
    parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] SRAM_BYTES  = 32'h0000_4000,
    parameter logic [ADDR_W-1:0] BOOT_BASE   = 32'h7FFF_E000,
    parameter logic [ADDR_W-1:0] BOOT_BYTES  = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = 32'hE01F_C040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phys_addr,
    output logic              sel_flash,
    output logic              sel_sram,
    output logic              sel_boot,
    output logic              decode_err
);
    logic cfg_hit;

    // Range compares via offset subtraction (wraps for addresses below base).
    always_comb begin
        sel_flash  = (phys_addr - FLASH_BASE) < FLASH_BYTES;
        sel_sram   = (phys_addr - SRAM_BASE)  < SRAM_BYTES;
        sel_boot   = (phys_addr - BOOT_BASE)  < BOOT_BYTES;
        cfg_hit    = (phys_addr == CFG_ADDR);
        decode_err = !(sel_flash || sel_sram || sel_boot || cfg_hit);
    end

    assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_flash, sel_sram, sel_boot}));

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |-> !(sel_flash || sel_sram || sel_boot));
endmodule

// File: rtl/vec_remap_ctrl.sv
// Module: top of the exception vector remap controller.
// Joins the mode register, the window translation and the region decode.
// Assumes a single core address port and a separate register bus.
module vec_remap_ctrl
    import remap_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                VEC_WORDS   = 8,
    parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] FLASH_BYTES = 32'h0004_0000,
    parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] SRAM_BYTES  = 32'h0000_4000,
    parameter logic [ADDR_W-1:0] BOOT_BASE   = 32'h7FFF_E000,
    parameter logic [ADDR_W-1:0] BOOT_BYTES  = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = 32'hE01F_C040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              sel_flash,
    output logic              sel_sram,
    output logic              sel_boot,
    output logic              decode_err,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_ready
);
    localparam int VEC_BYTES = VEC_WORDS * 4;

    map_mode_t mode;
    logic      vec_hit;

    assign vec_hit = cpu_addr < ADDR_W'(VEC_BYTES);

    remap_cfg_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .mode(mode)
    );

    remap_vector_xlate #(
        .ADDR_W(ADDR_W), .VEC_WORDS(VEC_WORDS),
        .BOOT_BASE(BOOT_BASE), .SRAM_BASE(SRAM_BASE)
    ) u_xlate (
        .mode(mode), .cpu_addr(cpu_addr), .phys_addr(phys_addr)
    );

    remap_region_decode #(
        .ADDR_W(ADDR_W),
        .FLASH_BASE(FLASH_BASE), .FLASH_BYTES(FLASH_BYTES),
        .SRAM_BASE(SRAM_BASE),   .SRAM_BYTES(SRAM_BYTES),
        .BOOT_BASE(BOOT_BASE),   .BOOT_BYTES(BOOT_BYTES),
        .CFG_ADDR(CFG_ADDR)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .phys_addr(phys_addr),
        .sel_flash(sel_flash), .sel_sram(sel_sram),
        .sel_boot(sel_boot), .decode_err(decode_err)
    );

    assert_boot_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hit && mode == MAP_BOOT) |-> sel_boot);

    assert_ram_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hit && mode == MAP_RAM) |-> sel_sram);

    assert_flash_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hit && mode[0]) |-> (sel_flash && phys_addr == cpu_addr));

    assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready == reg_valid);
endmodule

// File: tb/tb_vec_remap_ctrl.sv
// Bench: behavioural reference model compared against every output each cycle.
module tb_vec_remap_ctrl;
    localparam logic [31:0] CFG = 32'hE01F_C040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] phys_addr;
    logic        sel_flash, sel_sram, sel_boot, decode_err;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [31:0] reg_addr = '0, reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;

    int total = 0;
    int bad = 0;
    int model_mode = 0;

    always #4 clk = ~clk;

    vec_remap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
        .sel_flash(sel_flash), .sel_sram(sel_sram), .sel_boot(sel_boot),
        .decode_err(decode_err), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ready(reg_ready)
    );

    function automatic logic [31:0] ref_phys(logic [31:0] a, int m);
        if (a < 32'h20) begin
            if (m == 0) return 32'h7FFF_E000 + a;
            if (m == 2) return 32'h4000_0000 + a;
        end
        return a;
    endfunction

    // {flash, sram, boot, err}
    function automatic logic [3:0] ref_sel(logic [31:0] p);
        if (p < 32'h0004_0000) return 4'b1000;
        if (p >= 32'h4000_0000 && p < 32'h4000_4000) return 4'b0100;
        if (p >= 32'h7FFF_E000 && p <= 32'h7FFF_FFFF) return 4'b0010;
        if (p == CFG) return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic [31:0] a, bit rv, bit rw,
                        logic [31:0] ra, logic [31:0] wd);
        logic [31:0] ep;
        @(negedge clk);
        cpu_addr = a; reg_valid = rv; reg_write = rw; reg_addr = ra; reg_wdata = wd;
        #2;
        ep = ref_phys(a, model_mode);
        check({tag, " phys"}, phys_addr, ep);
        check({tag, " sel"}, {28'b0, sel_flash, sel_sram, sel_boot, decode_err},
              {28'b0, ref_sel(ep)});
        check("R10 ready", {31'b0, reg_ready}, {31'b0, rv});
        check({tag, " rdata"}, reg_rdata,
              (rv && !rw && ra == CFG) ? 32'(model_mode) : 32'h0);
        @(posedge clk);
        if (rst_n && rv && rw && ra == CFG) model_mode = int'(wd[1:0]);
    endtask

    task automatic fetch(string tag, logic [31:0] a);
        step(tag, a, 1'b0, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        model_mode = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state reads back 0
        step("R1 readback", 32'h8, 1'b1, 1'b0, CFG, 32'h0);
        // R2: boot mode window
        for (int i = 0; i < 32; i += 4) fetch("R2 boot vec", 32'(i));
        fetch("R2 boot vec edge", 32'h1F);
        // R6: natural regions in boot mode
        fetch("R6 flash", 32'h20);
        fetch("R6 flash top", 32'h0003_FFFC);
        fetch("R6 sram", 32'h4000_0008);
        fetch("R6 sram top", 32'h4000_3FFF);
        fetch("R6 boot", 32'h7FFF_E008);
        // R7: unmapped and register address
        fetch("R7 gap", 32'h0004_0000);
        fetch("R7 gap", 32'h4000_4000);
        fetch("R7 gap", 32'h8000_0000);
        fetch("R7 cfg", CFG);
        // R9: write flash mode; same-cycle access still boot
        step("R9 write cycle", 32'h8, 1'b1, 1'b1, CFG, 32'h1);
        fetch("R4 flash vec", 32'h8);
        fetch("R4 flash vec", 32'h1C);
        step("R8 readback", 32'h0, 1'b1, 1'b0, CFG, 32'h0);
        // R3: RAM mode
        step("R9 write ram", 32'h4, 1'b1, 1'b1, CFG, 32'h2);
        for (int i = 0; i < 32; i += 4) fetch("R3 ram vec", 32'(i));
        fetch("R6 ram mode flash", 32'h100);
        fetch("R6 ram mode boot", 32'h7FFF_FFFC);
        // R8: write to another address ignored
        step("R8 stray write", 32'h0, 1'b1, 1'b1, CFG + 32'h4, 32'h0);
        fetch("R8 stray ignored", 32'h8);
        step("R8 stray read", 32'h0, 1'b1, 1'b0, CFG + 32'h4, 32'h0);
        // R5/R8: reserved encoding with junk upper bits
        step("R8 write hi", 32'h0, 1'b1, 1'b1, CFG, 32'hFFFF_FFF7);
        fetch("R5 rsvd vec", 32'h8);
        step("R5 readback", 32'h0, 1'b1, 1'b0, CFG, 32'h0);
        // R1: reset mid-run restores boot
        do_reset();
        fetch("R1 boot again", 32'h8);
        step("R1 readback2", 32'h0, 1'b1, 1'b0, CFG, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule